// File: doc/BRIEF.md
# Skid-Buffered Decode Stage Controller

This block is the control and steering part of a superscalar decode stage. Each cycle it takes one bundle of up to `WIDTH` instruction records from the fetch side and hands the usable ones to the rename side. Instructions are opaque records here. The block only reads a few flag bits in each record, plus the sequence number and corrected next PC that it needs to redirect fetch.

When any of the rename, execute or commit stages requests a stall, the stage parks whole incoming bundles in a small skid buffer and holds fetch back. After the stall lifts, it replays the parked bundles in arrival order before it accepts live input. A squash from commit flushes everything and quiets the stage until commit releases it. If the stage itself finds a bad prediction, it redirects fetch, drops the younger slots of that bundle, flushes the buffer and spends one cycle squashing. Eight free-running counters record what the stage spent its cycles on and what happened to the instructions it saw.

Top module: `dec_stage_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `rn_valid` is zero, `fetch_stall` and `redir_valid` are low, and every counter output reads zero.
- R2: An instruction record is 37 bits. From the MSB down it holds: tag[36:29], seq[28:21], next_pc[20:5], squashed[4], pred_taken[3], is_ctrl[2], is_direct[1], mispred[0]. Slot i of a bundle occupies bits [i*37 +: 37]. When the stage is running with no stall or squash request, the first `fq_count` slots of the live bundle are forwarded on the next clock edge. Slots at or above `fq_count` are ignored.
- R3: A slot whose squashed bit is set is not forwarded. Forwarded records are packed into consecutive output slots starting at slot 0 in their original order, so `rn_valid` is always of the form 2^k-1. Each skipped record adds one to `cnt_skipped`, and each forwarded record adds one to `cnt_decoded`.
- R4: A stall request from any of `rn_stall`, `ex_stall` or `cm_stall` while running raises `fetch_stall` from the next cycle. The bundle presented in that cycle is parked, not forwarded.
- R5: While blocked, nothing is forwarded. Every non-empty arriving bundle is parked and empty bundles are not.
- R6: When all three stall requests are low in the blocked state, parked bundles are forwarded one per cycle in arrival order, before any live bundle. Non-empty bundles that arrive during the replay are appended behind them. `fetch_stall` stays high until the cycle after the last parked bundle is forwarded. If nothing was parked, the stage goes straight back to running.
- R7: `cm_squash` or `cm_rob_squash` discards all parked bundles and enters squashing. In that state the live input is discarded, nothing is forwarded, and `fetch_stall` is low. The stage leaves squashing once both inputs are low.
- R8: A forwarded record with pred_taken set and is_ctrl clear is a control mispredict. It is forwarded itself, the later slots of its bundle are dropped, and on the next edge `redir_valid` pulses for one cycle with its next_pc, its seq and `redir_branch`=0.
- R9: A forwarded record with is_ctrl, is_direct and mispred all set is a branch mispredict and is handled the same way with `redir_branch`=1. The mispred bit of a control record that is not direct causes no redirect.
- R10: A redirect discards all parked bundles and puts the stage into squashing for at least one cycle. The fetch bundle presented in that cycle is dropped, whether the mispredicting record came from live input or from replay.
- R11: `cnt_idle`, `cnt_blocked`, `cnt_unblock` and `cnt_squash` count cycles spent, respectively: running with no request and an empty bundle, blocked, replaying, and squashing.
- R12: `cnt_br_mis` and `cnt_ctrl_mis` count branch and control mispredicts detected by the stage.
- R13: The skid buffer holds up to `SKID_DEPTH` bundles. A buffer filled to exactly that depth replays every bundle intact, including a bundle pushed in the same cycle a bundle is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fq_count | input | $clog2(WIDTH+1) | Number of occupied slots in the live fetch bundle |
| fq_slots | input | WIDTH*37 | Live fetch bundle records |
| rn_stall | input | 1 | Stall request from rename |
| ex_stall | input | 1 | Stall request from execute |
| cm_stall | input | 1 | Stall request from commit |
| cm_squash | input | 1 | Squash request from commit |
| cm_rob_squash | input | 1 | Reorder-buffer squash in progress |
| rn_valid | output | WIDTH | Per-slot valid of the rename bundle |
| rn_slots | output | WIDTH*37 | Rename bundle records |
| fetch_stall | output | 1 | Hold request toward fetch |
| redir_valid | output | 1 | One-cycle redirect and squash toward fetch |
| redir_pc | output | 16 | Corrected next PC |
| redir_seq | output | 8 | Sequence number of the mispredicting record |
| redir_branch | output | 1 | 1 = branch mispredict, 0 = control mispredict |
| cnt_idle | output | CNT_W | Idle cycle count |
| cnt_blocked | output | CNT_W | Blocked cycle count |
| cnt_unblock | output | CNT_W | Replay cycle count |
| cnt_squash | output | CNT_W | Squashing cycle count |
| cnt_decoded | output | CNT_W | Forwarded record count |
| cnt_skipped | output | CNT_W | Skipped squashed record count |
| cnt_br_mis | output | CNT_W | Branch mispredict count |
| cnt_ctrl_mis | output | CNT_W | Control mispredict count |

## Verification
The checker assumes that the producer never parks more than `SKID_DEPTH` bundles, so the overflow property only holds if the stall-propagation latency fits the buffer. It also assumes that commit squash requests are never mixed with stall requests in a way that would need both a park and a flush in the same cycle, because the flush simply wins. The stimulus parks at most four bundles with the default depth of four, reaching the limit exactly once. It raises each squash or stall request on its own or in a known order, so every expected rename bundle and redirect can be listed in advance in the scoreboard.

// File: rtl/dec_pkg.sv
package dec_pkg;

  localparam int TAG_W = 8;
  localparam int SEQ_W = 8;
  localparam int PC_W  = 16;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [SEQ_W-1:0] seq;
    logic [PC_W-1:0]  next_pc;
    logic             squashed;
    logic             pred_taken;
    logic             is_ctrl;
    logic             is_direct;
    logic             mispred;
  } dec_inst_t;

  localparam int INST_W = $bits(dec_inst_t);

  typedef enum logic [1:0] {
    ST_RUN,
    ST_BLOCK,
    ST_UNBLOCK,
    ST_SQUASH
  } dec_state_e;

  // predicted taken, but the record is not a control transfer
  function automatic logic ctrl_mispredict(input dec_inst_t r);
    return r.pred_taken & ~r.is_ctrl;
  endfunction

  // direct control transfer whose prediction proved wrong
  function automatic logic branch_mispredict(input dec_inst_t r);
    return r.is_ctrl & r.is_direct & r.mispred;
  endfunction

endpackage

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign do_pop  = pop && (count != '0);
  assign do_push = push && ((count != CNT_W'(DEPTH)) || do_pop);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/dec_slot_pack.sv
module dec_slot_pack import dec_pkg::*; #(
  parameter int WIDTH = 4,
  localparam int CW   = $clog2(WIDTH + 1)
) (
  input  logic [CW-1:0]           n_in,
  input  logic [WIDTH*INST_W-1:0] slots_flat,
  output logic [WIDTH-1:0]        out_valid,
  output logic [WIDTH*INST_W-1:0] out_flat,
  output logic [CW-1:0]           n_fwd,
  output logic [CW-1:0]           n_skip,
  output logic                    hit,
  output logic                    hit_branch,
  output logic [PC_W-1:0]         hit_pc,
  output logic [SEQ_W-1:0]        hit_seq
);

  dec_inst_t slot_in [WIDTH];
  dec_inst_t out_arr [WIDTH];
  logic      keep    [WIDTH];
  int        dest    [WIDTH];
  int        k, nskip;
  logic      stop;

  for (genvar g = 0; g < WIDTH; g++) begin : g_split
    assign slot_in[g] = slots_flat[g*INST_W +: INST_W];
    assign out_flat[g*INST_W +: INST_W] = out_arr[g];
  end

  // scan slots in order: choose destinations, stop after a mispredict
  always_comb begin
    k          = 0;
    nskip      = 0;
    stop       = 1'b0;
    hit        = 1'b0;
    hit_branch = 1'b0;
    hit_pc     = '0;
    hit_seq    = '0;
    for (int i = 0; i < WIDTH; i++) begin
      keep[i] = 1'b0;
      dest[i] = 0;
      if (!stop && (i < int'(n_in))) begin
        if (slot_in[i].squashed) begin
          nskip = nskip + 1;
        end else begin
          keep[i] = 1'b1;
          dest[i] = k;
          k = k + 1;
          if (ctrl_mispredict(slot_in[i]) || branch_mispredict(slot_in[i])) begin
            stop       = 1'b1;
            hit        = 1'b1;
            hit_branch = branch_mispredict(slot_in[i]);
            hit_pc     = slot_in[i].next_pc;
            hit_seq    = slot_in[i].seq;
          end
        end
      end
    end
    n_fwd  = CW'(k);
    n_skip = CW'(nskip);
  end

  // compact kept slots toward slot 0
  always_comb begin
    for (int j = 0; j < WIDTH; j++) begin
      out_arr[j]   = '0;
      out_valid[j] = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
        if (keep[i] && (dest[i] == j)) begin
          out_arr[j]   = slot_in[i];
          out_valid[j] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dec_event_ctr.sv
module dec_event_ctr #(
  parameter int CNT_W = 16,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= value + CNT_W'(inc);
  end

endmodule

// File: rtl/dec_stage_ctrl.sv
module dec_stage_ctrl import dec_pkg::*; #(
  parameter int WIDTH      = 4,
  parameter int SKID_DEPTH = 4,
  parameter int CNT_W      = 16,
  localparam int CW        = $clog2(WIDTH + 1),
  localparam int SC_W      = $clog2(SKID_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           fq_count,
  input  logic [WIDTH*INST_W-1:0] fq_slots,
  input  logic                    rn_stall,
  input  logic                    ex_stall,
  input  logic                    cm_stall,
  input  logic                    cm_squash,
  input  logic                    cm_rob_squash,
  output logic [WIDTH-1:0]        rn_valid,
  output logic [WIDTH*INST_W-1:0] rn_slots,
  output logic                    fetch_stall,
  output logic                    redir_valid,
  output logic [PC_W-1:0]         redir_pc,
  output logic [SEQ_W-1:0]        redir_seq,
  output logic                    redir_branch,
  output logic [CNT_W-1:0]        cnt_idle,
  output logic [CNT_W-1:0]        cnt_blocked,
  output logic [CNT_W-1:0]        cnt_unblock,
  output logic [CNT_W-1:0]        cnt_squash,
  output logic [CNT_W-1:0]        cnt_decoded,
  output logic [CNT_W-1:0]        cnt_skipped,
  output logic [CNT_W-1:0]        cnt_br_mis,
  output logic [CNT_W-1:0]        cnt_ctrl_mis
);

  localparam int BUN_W = CW + WIDTH * INST_W;
  localparam int NCTR  = 8;
  localparam int C_IDLE = 0, C_BLK = 1, C_UNB = 2, C_SQ = 3;
  localparam int C_DEC = 4, C_SKIP = 5, C_BR = 6, C_CTRL = 7;

  dec_state_e state, nxt_state;

  // named internal events
  logic             live_ne, stall_req, squash_req;
  logic             skid_push, skid_pop, skid_flush, use_skid, proc;
  logic [SC_W-1:0]  skid_cnt;
  logic [BUN_W-1:0] skid_dout, sel_bundle;

  logic [WIDTH-1:0]        pk_valid;
  logic [WIDTH*INST_W-1:0] pk_flat;
  logic [CW-1:0]           pk_n_fwd, pk_n_skip;
  logic                    pk_hit, pk_branch;
  logic [PC_W-1:0]         pk_pc;
  logic [SEQ_W-1:0]        pk_seq;

  assign live_ne    = (fq_count != '0);
  assign stall_req  = rn_stall | ex_stall | cm_stall;
  assign squash_req = cm_squash | cm_rob_squash;
  assign sel_bundle = use_skid ? skid_dout : {fq_count, fq_slots};

  dec_skid_fifo #(.DATA_W(BUN_W), .DEPTH(SKID_DEPTH)) u_skid (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (skid_push),
    .pop   (skid_pop),
    .flush (skid_flush),
    .din   ({fq_count, fq_slots}),
    .dout  (skid_dout),
    .count (skid_cnt)
  );

  dec_slot_pack #(.WIDTH(WIDTH)) u_pack (
    .n_in       (sel_bundle[BUN_W-1 -: CW]),
    .slots_flat (sel_bundle[WIDTH*INST_W-1:0]),
    .out_valid  (pk_valid),
    .out_flat   (pk_flat),
    .n_fwd      (pk_n_fwd),
    .n_skip     (pk_n_skip),
    .hit        (pk_hit),
    .hit_branch (pk_branch),
    .hit_pc     (pk_pc),
    .hit_seq    (pk_seq)
  );

  // control machine: squash beats stall beats processing
  always_comb begin
    nxt_state  = state;
    skid_push  = 1'b0;
    skid_pop   = 1'b0;
    skid_flush = 1'b0;
    use_skid   = 1'b0;
    proc       = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (squash_req) begin
          skid_flush = 1'b1;
          nxt_state  = ST_SQUASH;
        end else if (stall_req) begin
          skid_push = live_ne;
          nxt_state = ST_BLOCK;
        end else begin
          proc = live_ne;
          if (live_ne && pk_hit) begin
            skid_flush = 1'b1;
            nxt_state  = ST_SQUASH;
          end
        end
      end
      ST_BLOCK: begin
        if (squash_req) begin
          skid_flush = 1'b1;
          nxt_state  = ST_SQUASH;
        end else begin
          skid_push = live_ne;
          if (!stall_req)
            nxt_state = ((skid_cnt != '0) || live_ne) ? ST_UNBLOCK : ST_RUN;
        end
      end
      ST_UNBLOCK: begin
        if (squash_req) begin
          skid_flush = 1'b1;
          nxt_state  = ST_SQUASH;
        end else if (stall_req) begin
          skid_push = live_ne;
          nxt_state = ST_BLOCK;
        end else begin
          proc      = 1'b1;
          use_skid  = 1'b1;
          skid_pop  = 1'b1;
          skid_push = live_ne;
          if (pk_hit) begin
            skid_flush = 1'b1;
            nxt_state  = ST_SQUASH;
          end else if ((skid_cnt == SC_W'(1)) && !live_ne) begin
            nxt_state = ST_RUN;
          end
        end
      end
      ST_SQUASH: begin
        if (!squash_req) nxt_state = ST_RUN;
      end
      default: nxt_state = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      rn_valid     <= '0;
      rn_slots     <= '0;
      redir_valid  <= 1'b0;
      redir_pc     <= '0;
      redir_seq    <= '0;
      redir_branch <= 1'b0;
    end else begin
      state       <= nxt_state;
      rn_valid    <= proc ? pk_valid : '0;
      rn_slots    <= proc ? pk_flat : '0;
      redir_valid <= proc & pk_hit;
      if (proc && pk_hit) begin
        redir_pc     <= pk_pc;
        redir_seq    <= pk_seq;
        redir_branch <= pk_branch;
      end
    end
  end

  assign fetch_stall = (state == ST_BLOCK) || (state == ST_UNBLOCK);

  // activity counters
  logic [NCTR-1:0][CW-1:0]    ctr_inc;
  logic [NCTR-1:0][CNT_W-1:0] ctr_val;

  assign ctr_inc[C_IDLE] = CW'((state == ST_RUN) && !squash_req && !stall_req && !live_ne);
  assign ctr_inc[C_BLK]  = CW'(state == ST_BLOCK);
  assign ctr_inc[C_UNB]  = CW'(state == ST_UNBLOCK);
  assign ctr_inc[C_SQ]   = CW'(state == ST_SQUASH);
  assign ctr_inc[C_DEC]  = proc ? pk_n_fwd : '0;
  assign ctr_inc[C_SKIP] = proc ? pk_n_skip : '0;
  assign ctr_inc[C_BR]   = CW'(proc && pk_hit && pk_branch);
  assign ctr_inc[C_CTRL] = CW'(proc && pk_hit && !pk_branch);

  for (genvar c = 0; c < NCTR; c++) begin : g_ctr
    dec_event_ctr #(.CNT_W(CNT_W), .INC_W(CW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ctr_inc[c]),
      .value (ctr_val[c])
    );
  end

  assign cnt_idle     = ctr_val[C_IDLE];
  assign cnt_blocked  = ctr_val[C_BLK];
  assign cnt_unblock  = ctr_val[C_UNB];
  assign cnt_squash   = ctr_val[C_SQ];
  assign cnt_decoded  = ctr_val[C_DEC];
  assign cnt_skipped  = ctr_val[C_SKIP];
  assign cnt_br_mis   = ctr_val[C_BR];
  assign cnt_ctrl_mis = ctr_val[C_CTRL];

endmodule

// File: rtl/dec_stage_ctrl_chk.sv
module dec_stage_ctrl_chk import dec_pkg::*; #(
  parameter int WIDTH      = 4,
  parameter int SKID_DEPTH = 4,
  localparam int SC_W      = $clog2(SKID_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input dec_state_e       state,
  input logic [SC_W-1:0]  skid_cnt,
  input logic             skid_push,
  input logic             skid_pop,
  input logic             skid_flush,
  input logic             stall_req,
  input logic             squash_req,
  input logic [WIDTH-1:0] rn_valid,
  input logic             redir_valid,
  input logic             fetch_stall
);

  // R13: never park into a full buffer
  a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (skid_push && !skid_pop && !skid_flush) |-> (skid_cnt != SC_W'(SKID_DEPTH)));

  // R4: a stall while running holds fetch on the next cycle
  a_r4_stall_holds_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && stall_req && !squash_req) |=> (fetch_stall && state == ST_BLOCK));

  // R5: nothing leaves while blocked
  a_r5_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BLOCK) |=> (rn_valid == '0));

  // R6: replay only happens from a non-empty buffer
  a_r6_replay_source: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UNBLOCK) |-> (skid_cnt != '0));

  // R7: commit squash empties the buffer and enters squashing
  a_r7_squash_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    squash_req |=> (state == ST_SQUASH && skid_cnt == '0));

  // R7: squashing produces no output and no redirect
  a_r7_squash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SQUASH) |=> (rn_valid == '0 && !redir_valid));

  // R3: output slots are packed from slot 0
  a_r3_packed: assert property (@(posedge clk) disable iff (!rst_n)
    ((rn_valid & (rn_valid + WIDTH'(1))) == '0));

  // R10: a redirect coincides with squashing
  a_r10_redirect_squashes: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (state == ST_SQUASH && skid_cnt == '0));

endmodule

bind dec_stage_ctrl dec_stage_ctrl_chk #(.WIDTH(WIDTH), .SKID_DEPTH(SKID_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state       (state),
  .skid_cnt    (skid_cnt),
  .skid_push   (skid_push),
  .skid_pop    (skid_pop),
  .skid_flush  (skid_flush),
  .stall_req   (stall_req),
  .squash_req  (squash_req),
  .rn_valid    (rn_valid),
  .redir_valid (redir_valid),
  .fetch_stall (fetch_stall)
);

// File: tb/dec_stage_ctrl_bench.sv
`timescale 1ns/1ps
module dec_stage_ctrl_bench;

  localparam int W   = 4;
  localparam int IW  = 37;
  localparam int CW  = 3;
  localparam int CTW = 16;
  localparam int BW  = W * IW;

  localparam logic [4:0] NONE = 5'd0, RS = 5'd1, ES = 5'd2, CS = 5'd4, CSQ = 5'd8, ROB = 5'd16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] fq_count = '0;
  logic [BW-1:0] fq_slots = '0;
  logic rn_stall = 0, ex_stall = 0, cm_stall = 0, cm_squash = 0, cm_rob_squash = 0;
  logic [W-1:0]  rn_valid;
  logic [BW-1:0] rn_slots;
  logic fetch_stall, redir_valid, redir_branch;
  logic [15:0] redir_pc;
  logic [7:0]  redir_seq;
  logic [CTW-1:0] cnt_idle, cnt_blocked, cnt_unblock, cnt_squash;
  logic [CTW-1:0] cnt_decoded, cnt_skipped, cnt_br_mis, cnt_ctrl_mis;

  int checks = 0, errors = 0;

  logic [W+BW-1:0] fwd_q [$];
  logic [24:0]     rd_q  [$];

  always #2 clk = ~clk;

  dec_stage_ctrl u_dec_stage_ctrl (
    .clk(clk), .rst_n(rst_n), .fq_count(fq_count), .fq_slots(fq_slots),
    .rn_stall(rn_stall), .ex_stall(ex_stall), .cm_stall(cm_stall),
    .cm_squash(cm_squash), .cm_rob_squash(cm_rob_squash),
    .rn_valid(rn_valid), .rn_slots(rn_slots), .fetch_stall(fetch_stall),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_seq(redir_seq),
    .redir_branch(redir_branch),
    .cnt_idle(cnt_idle), .cnt_blocked(cnt_blocked), .cnt_unblock(cnt_unblock),
    .cnt_squash(cnt_squash), .cnt_decoded(cnt_decoded), .cnt_skipped(cnt_skipped),
    .cnt_br_mis(cnt_br_mis), .cnt_ctrl_mis(cnt_ctrl_mis)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // record builder: tag, seq, next pc, then the five flag bits
  function automatic logic [IW-1:0] mk(input int tag, input int seq, input int pc,
                                       input bit sq, input bit pt, input bit ctl,
                                       input bit dir, input bit mis);
    logic [IW-1:0] r;
    r = '0;
    r = r | (IW'(tag & 8'hFF) << 29);
    r = r | (IW'(seq & 8'hFF) << 21);
    r = r | (IW'(pc & 16'hFFFF) << 5);
    r = r | (IW'(sq) << 4) | (IW'(pt) << 3) | (IW'(ctl) << 2) | (IW'(dir) << 1) | IW'(mis);
    return r;
  endfunction

  function automatic logic [IW-1:0] plain(input int tag);
    return mk(tag, tag + 1, tag * 16, 0, 0, 0, 0, 0);
  endfunction

  function automatic logic [BW-1:0] bun(input logic [IW-1:0] a, input logic [IW-1:0] b,
                                        input logic [IW-1:0] c, input logic [IW-1:0] d);
    return {d, c, b, a};
  endfunction

  // expected rename bundle from the requirements
  task automatic exp_fwd(input int n, input logic [BW-1:0] s);
    logic [W-1:0]  mask;
    logic [BW-1:0] o;
    logic [IW-1:0] r;
    int k;
    mask = '0; o = '0; k = 0;
    for (int i = 0; i < n; i++) begin
      r = s[i*IW +: IW];
      if (r[4]) continue;
      o[k*IW +: IW] = r;
      mask[k] = 1'b1;
      k++;
      if ((r[3] && !r[2]) || (r[2] && r[1] && r[0])) break;
    end
    fwd_q.push_back({mask, o});
  endtask

  task automatic exp_redir(input int pc, input int seq, input bit br);
    rd_q.push_back({16'(pc), 8'(seq), br});
  endtask

  task automatic step(input int n, input logic [BW-1:0] s, input logic [4:0] ctl);
    @(negedge clk);
    fq_count = CW'(n);
    fq_slots = s;
    {cm_rob_squash, cm_squash, cm_stall, ex_stall, rn_stall} = ctl;
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  initial begin
    logic [W+BW-1:0] e;
    logic [24:0]     rr;
    wait (rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (rn_valid != '0) begin
        if (fwd_q.size() == 0) begin
          check("R2 unexpected bundle", 64'(rn_valid), 64'h0);
        end else begin
          e = fwd_q.pop_front();
          check("R2/R3 valid mask", 64'(rn_valid), 64'(e[BW +: W]));
          for (int j = 0; j < W; j++)
            if (e[BW + j]) check("R2 slot record", 64'(rn_slots[j*IW +: IW]), 64'(e[j*IW +: IW]));
        end
      end
      if (redir_valid) begin
        if (rd_q.size() == 0) begin
          check("R8 unexpected redirect", 64'(redir_valid), 64'h0);
        end else begin
          rr = rd_q.pop_front();
          check("R8/R9 redirect", 64'({redir_pc, redir_seq, redir_branch}), 64'(rr));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [BW-1:0] a, b, c, d, e2, x;
    logic [CTW-1:0] s0, s1, s2, s3;

    repeat (3) @(posedge clk);
    #1;
    check("R1 rn_valid in reset", 64'(rn_valid), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R1 rn_valid", 64'(rn_valid), 64'h0);
    check("R1 fetch_stall", 64'(fetch_stall), 64'h0);
    check("R1 redir_valid", 64'(redir_valid), 64'h0);
    check("R1 counters", 64'(cnt_idle | cnt_blocked | cnt_unblock | cnt_squash |
                             cnt_decoded | cnt_skipped | cnt_br_mis | cnt_ctrl_mis), 64'h0);

    // R2: partial and full bundles, junk beyond the count
    a = bun(plain(1), plain(2), plain(3), mk(8'hEE, 9, 9, 0, 1, 0, 0, 0));
    exp_fwd(3, a);
    step(3, a, NONE);
    check("R2 three slots", 64'(rn_valid), 64'h7);
    b = bun(plain(4), plain(5), plain(6), plain(7));
    exp_fwd(4, b);
    step(4, b, NONE);
    check("R2 four slots", 64'(rn_valid), 64'hF);

    // R3: squashed slot skipped and gap closed
    s0 = cnt_decoded; s1 = cnt_skipped;
    c = bun(plain(10), mk(11, 11, 0, 1, 0, 0, 0, 0), plain(12), plain(13));
    exp_fwd(4, c);
    step(4, c, NONE);
    check("R3 packed mask", 64'(rn_valid), 64'h7);
    check("R3 decoded count", 64'(cnt_decoded - s0), 64'd3);
    check("R3 skipped count", 64'(cnt_skipped - s1), 64'd1);

    // R11: idle cycles
    s0 = cnt_idle;
    step(0, '0, NONE); step(0, '0, NONE); step(0, '0, NONE);
    check("R11 idle count", 64'(cnt_idle - s0), 64'd3);

    // R4 R5 R6 R13: park four bundles, append one during replay
    s0 = cnt_blocked; s1 = cnt_unblock;
    a  = bun(plain(20), '0, '0, '0);
    b  = bun(plain(21), plain(22), '0, '0);
    c  = bun(plain(23), '0, '0, '0);
    e2 = bun(plain(24), plain(25), plain(26), '0);
    d  = bun(plain(27), '0, '0, '0);
    exp_fwd(1, a); exp_fwd(2, b); exp_fwd(1, c); exp_fwd(3, e2); exp_fwd(1, d);
    step(1, a, ES);
    check("R4 fetch_stall raised", 64'(fetch_stall), 64'h1);
    check("R4 parked not forwarded", 64'(rn_valid), 64'h0);
    step(2, b, RS);
    step(0, '0, CS);
    step(1, c, RS);
    step(3, e2, ES);
    check("R5 blocked no output", 64'(rn_valid), 64'h0);
    step(0, '0, NONE);
    check("R6 stall held at release", 64'(fetch_stall), 64'h1);
    step(1, d, NONE);
    check("R13 first replay", 64'(rn_valid), 64'h1);
    step(0, '0, NONE);
    step(0, '0, NONE);
    step(0, '0, NONE);
    check("R6 stall held until drained", 64'(fetch_stall), 64'h1);
    step(0, '0, NONE);
    check("R6 stall dropped after drain", 64'(fetch_stall), 64'h0);
    check("R6 replay complete", 64'(fwd_q.size()), 64'd0);
    check("R11 blocked count", 64'(cnt_blocked - s0), 64'd5);
    check("R11 unblock count", 64'(cnt_unblock - s1), 64'd5);

    // R6: block with nothing parked goes straight back to running
    step(0, '0, ES);
    step(0, '0, NONE);
    check("R6 empty release", 64'(fetch_stall), 64'h0);

    // R7: commit squash flushes parked bundles and drops input
    s0 = cnt_squash;
    step(1, bun(plain(30), '0, '0, '0), ES);
    step(1, bun(plain(31), '0, '0, '0), NONE);
    check("R7 replaying before squash", 64'(fetch_stall), 64'h1);
    step(1, bun(plain(32), '0, '0, '0), CSQ);
    check("R7 no output on squash", 64'(rn_valid), 64'h0);
    check("R7 fetch_stall low", 64'(fetch_stall), 64'h0);
    step(1, bun(plain(33), '0, '0, '0), ROB);
    step(1, bun(plain(34), '0, '0, '0), NONE);
    check("R7 input dropped", 64'(rn_valid), 64'h0);
    x = bun(plain(35), '0, '0, '0);
    exp_fwd(1, x);
    step(1, x, NONE);
    check("R7 resumed", 64'(rn_valid), 64'h1);
    check("R11 squash count", 64'(cnt_squash - s0), 64'd2);

    // R8 R10: control mispredict in slot 1
    s0 = cnt_ctrl_mis; s1 = cnt_decoded;
    a = bun(plain(40), mk(41, 8'h21, 16'h1234, 0, 1, 0, 0, 0), plain(42), plain(43));
    exp_fwd(4, a);
    exp_redir(16'h1234, 8'h21, 0);
    step(4, a, NONE);
    check("R8 younger slots dropped", 64'(rn_valid), 64'h3);
    check("R8 redirect", 64'(redir_valid), 64'h1);
    check("R12 ctrl mispredict count", 64'(cnt_ctrl_mis - s0), 64'd1);
    check("R3 decoded stops at mispredict", 64'(cnt_decoded - s1), 64'd2);
    step(2, bun(plain(44), plain(45), '0, '0), NONE);
    check("R10 next bundle dropped", 64'(rn_valid), 64'h0);
    check("R8 redirect one cycle", 64'(redir_valid), 64'h0);

    // R9: branch mispredict behind a squashed slot
    s0 = cnt_br_mis;
    b = bun(mk(50, 50, 0, 1, 0, 0, 0, 0), mk(51, 8'h30, 16'h4000, 0, 0, 1, 1, 1), plain(52), '0);
    exp_fwd(3, b);
    exp_redir(16'h4000, 8'h30, 1);
    step(3, b, NONE);
    check("R9 branch redirect", 64'({redir_valid, redir_branch}), 64'h3);
    check("R12 branch mispredict count", 64'(cnt_br_mis - s0), 64'd1);
    step(0, '0, NONE);
    c = bun(mk(53, 53, 0, 0, 0, 1, 0, 1), plain(54), '0, '0);
    exp_fwd(2, c);
    step(2, c, NONE);
    check("R9 indirect no redirect", 64'(redir_valid), 64'h0);
    check("R9 indirect forwarded", 64'(rn_valid), 64'h3);

    // R10: mispredict found during replay flushes the rest
    d = bun(mk(60, 8'h61, 16'h0ABC, 0, 1, 0, 0, 0), plain(61), '0, '0);
    step(2, d, RS);
    step(1, bun(plain(62), '0, '0, '0), NONE);
    exp_fwd(2, d);
    exp_redir(16'h0ABC, 8'h61, 0);
    step(0, '0, NONE);
    check("R10 replay redirect", 64'(redir_valid), 64'h1);
    check("R10 stall released by flush", 64'(fetch_stall), 64'h0);
    step(0, '0, NONE);
    step(0, '0, NONE);
    step(0, '0, NONE);
    check("R10 flushed bundle never forwarded", 64'(rn_valid), 64'h0);

    check("R2 all bundles seen", 64'(fwd_q.size()), 64'd0);
    check("R8 all redirects seen", 64'(rd_q.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule